// File: doc/BRIEF.md
# Quadrature Position Decoder

This block turns the two phase signals of an incremental encoder into a signed position count. Each phase first passes through a clock-domain synchroniser. The synchronised pair is then examined only when a periodic sample strobe is high, and each sample is compared with the state taken at the previous strobe. The block always follows all four quadrature states, whatever resolution is selected, so the direction flag stays correct. The resolution input only decides which of those steps change the count.

If both phases change within one sample period, the step is illegal: it produces no count, and it sets a sticky error flag that is cleared by a dedicated input. Each change of the count also raises a one-cycle event on `evt_valid`, with `evt_up` giving its direction, for downstream rate logic. This event output is valid-only and has no ready. It cannot apply back-pressure, so the consumer must accept every pulse in the cycle it appears. Position and direction are plain status outputs.

Top module: `quad_decoder`

## Requirements
- R1: While `rst_n` is low, `position` is 0, `dir_fwd` is 1, `err_flag` is 0 and `evt_valid` is 0.
- R2: Phase inputs pass through `SYNC_STAGES` (default 2) flops and are examined only on strobe edges. A phase that toggles and returns between two strobes causes no count.
- R3: The quadrature state is written {B,A}. Forward order is 00→01→11→10→00. With `mode` 2 (or 3), every valid step counts: +1 forward, −1 reverse.
- R4: With `mode` 1, only valid steps in which A changes are counted, so a full forward cycle adds 2 and a full reverse cycle subtracts 2.
- R5: With `mode` 0, only a rise of A is counted. The count goes +1 when B is 0 and −1 when B is 1, so a full cycle moves the count by exactly ±1.
- R6: `dir_fwd` takes the direction of every valid step, in all modes, including steps that produce no count.
- R7: If both phases differ from the previous sample, the count, the event and the direction are unchanged and `err_flag` is set. The new state becomes the reference for the next sample.
- R8: `err_flag` stays set until `err_clr` is high at a clock edge. An illegal step in the same cycle keeps it set.
- R9: `pos_clr` zeroes `position` at the next edge, takes priority over a count in the same cycle and suppresses that event.
- R10: `evt_valid` is high for exactly the cycle after a counting strobe edge. In that same cycle `position` already holds the new value and `evt_up` gives the step's direction.
- R11: The count is two's-complement modular: counting down from 0 gives all ones.
- R12: The first strobe after reset only loads the reference state. It produces no count and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_en | input | 1 | Sample strobe, one clock wide |
| ph_a | input | 1 | Encoder phase A, asynchronous |
| ph_b | input | 1 | Encoder phase B, asynchronous |
| mode | input | 2 | Resolution: 0 = 1x, 1 = 2x, 2 or 3 = 4x |
| pos_clr | input | 1 | Synchronous clear of the position |
| err_clr | input | 1 | Clears the sticky error flag |
| position | output | POS_W | Signed position count |
| dir_fwd | output | 1 | Direction of the last valid step, 1 = forward |
| err_flag | output | 1 | Sticky illegal-transition flag |
| evt_valid | output | 1 | One-cycle count event |
| evt_up | output | 1 | Direction of the count event, 1 = up |

## Verification
The hardest case to create is an illegal step: both phases must move together inside a single sample period, while the synchroniser delay keeps shifting which strobe sees the change. The bench flips both phases at once, and it also places strobes at random offsets from phase changes. That way some samples catch a half-propagated pair and others skip a whole step. Collisions of a clear with a counting or illegal strobe are also forced, because a randomly timed stimulus seldom produces them.

// File: rtl/qdec_pkg.sv
package qdec_pkg;
  typedef enum logic [1:0] {
    RES_X1  = 2'd0,
    RES_X2  = 2'd1,
    RES_X4  = 2'd2,
    RES_X4B = 2'd3
  } res_e;

  // Map the {B,A} Gray state to its position along the forward cycle.
  function automatic logic [1:0] phase_idx(input logic [1:0] ba);
    return {ba[1], ba[1] ^ ba[0]};
  endfunction
endpackage

// File: rtl/qdec_sync.sv
module qdec_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= stage_q[g-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/qdec_step.sv
module qdec_step
  import qdec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       smp_en,
  input  logic [1:0] ba_i,
  input  logic [1:0] mode_i,
  output logic       move_o,
  output logic       up_o,
  output logic       cnt_o,
  output logic       bad_o
);
  logic [1:0] prev_q;
  logic       primed_q;
  logic [1:0] delta;
  logic       live, a_chg, a_rise;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      prev_q   <= 2'b00;
      primed_q <= 1'b0;
    end else if (smp_en) begin
      prev_q   <= ba_i;
      primed_q <= 1'b1;
    end

  always_comb begin
    delta  = phase_idx(ba_i) - phase_idx(prev_q);
    live   = smp_en && primed_q;
    move_o = live && (delta == 2'd1 || delta == 2'd3);
    up_o   = (delta == 2'd1);
    bad_o  = live && (delta == 2'd2);
    a_chg  = ba_i[0] ^ prev_q[0];
    a_rise = ba_i[0] & ~prev_q[0];
    case (res_e'(mode_i))
      RES_X1:  cnt_o = move_o && a_rise;
      RES_X2:  cnt_o = move_o && a_chg;
      default: cnt_o = move_o;
    endcase
  end

  // R12: nothing is decoded before the first reference sample.
  p_prime_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !primed_q |-> !move_o && !bad_o);
endmodule

// File: rtl/qdec_count.sv
module qdec_count #(
  parameter int POS_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             move_i,
  input  logic             up_i,
  input  logic             cnt_i,
  input  logic             bad_i,
  input  logic             pos_clr,
  input  logic             err_clr,
  output logic [POS_W-1:0] position,
  output logic             dir_fwd,
  output logic             err_flag,
  output logic             evt_valid,
  output logic             evt_up
);
  localparam logic [POS_W-1:0] ONE = POS_W'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      position  <= '0;
      dir_fwd   <= 1'b1;
      err_flag  <= 1'b0;
      evt_valid <= 1'b0;
      evt_up    <= 1'b1;
    end else begin
      if (move_i) dir_fwd <= up_i;
      if (bad_i)        err_flag <= 1'b1;
      else if (err_clr) err_flag <= 1'b0;
      if (pos_clr) begin
        position  <= '0;
        evt_valid <= 1'b0;
      end else begin
        evt_valid <= cnt_i;
        if (cnt_i) begin
          evt_up   <= up_i;
          position <= up_i ? position + ONE : position - ONE;
        end
      end
    end

  p_evt_up_r10: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && evt_up |-> position == $past(position) + ONE);
  p_evt_dn_r11: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && !evt_up |-> position == $past(position) - ONE);
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_i && !pos_clr |=> $stable(position) && !evt_valid);
  p_bad_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bad_i |=> err_flag && !evt_valid && $stable(dir_fwd));
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag && !err_clr |=> err_flag);
endmodule

// File: rtl/quad_decoder.sv
module quad_decoder #(
  parameter int POS_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_en,
  input  logic             ph_a,
  input  logic             ph_b,
  input  logic [1:0]       mode,
  input  logic             pos_clr,
  input  logic             err_clr,
  output logic [POS_W-1:0] position,
  output logic             dir_fwd,
  output logic             err_flag,
  output logic             evt_valid,
  output logic             evt_up
);
  logic [1:0] ba_s;
  logic move, up, cnt, bad;

  qdec_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i({ph_b, ph_a}), .q_o(ba_s));

  qdec_step u_step (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .ba_i(ba_s), .mode_i(mode),
    .move_o(move), .up_o(up), .cnt_o(cnt), .bad_o(bad));

  qdec_count #(.POS_W(POS_W)) u_count (
    .clk(clk), .rst_n(rst_n), .move_i(move), .up_i(up), .cnt_i(cnt),
    .bad_i(bad), .pos_clr(pos_clr), .err_clr(err_clr), .position(position),
    .dir_fwd(dir_fwd), .err_flag(err_flag), .evt_valid(evt_valid),
    .evt_up(evt_up));

  p_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pos_clr |=> position == '0 && !evt_valid);
endmodule

// File: tb/sim_quad_decoder.sv
`timescale 1ns/1ps
module sim_quad_decoder;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, smp_en = 1'b0, ph_a = 1'b0, ph_b = 1'b0;
  logic pos_clr = 1'b0, err_clr = 1'b0;
  logic [1:0] mode = 2'd2;
  logic [31:0] position;
  logic dir_fwd, err_flag, evt_valid, evt_up;

  quad_decoder u0 (.*);

  int checks = 0, errors = 0;
  bit done = 0, cmp_on = 0;
  logic [1:0] st = 2'b00;

  // reference model state
  logic m_a1, m_a2, m_b1, m_b2, m_primed, m_dir, m_err, m_evt, m_up;
  logic [1:0] m_prev;
  logic [31:0] m_pos;

  function automatic int ord(input logic [1:0] ba);
    case (ba)
      2'b00: return 0;
      2'b01: return 1;
      2'b11: return 2;
      default: return 3;
    endcase
  endfunction

  always @(posedge clk) begin : model
    logic [1:0] cur; int d; logic c, u, bad;
    if (!rst_n) begin
      {m_a1, m_a2, m_b1, m_b2, m_primed, m_err, m_evt} = '0;
      m_dir = 1; m_up = 1; m_prev = 0; m_pos = 0;
    end else begin
      cur = {m_b2, m_a2};
      m_b2 = m_b1; m_a2 = m_a1; m_b1 = ph_b; m_a1 = ph_a;
      c = 0; u = 0; bad = 0;
      if (smp_en) begin
        if (!m_primed) begin
          m_primed = 1; m_prev = cur;
        end else begin
          d = (ord(cur) - ord(m_prev) + 4) % 4;
          if (d == 2) bad = 1;
          else if (d != 0) begin
            u = (d == 1); m_dir = u;
            if (mode == 2'd0)      c = !m_prev[0] && cur[0];
            else if (mode == 2'd1) c = m_prev[0] != cur[0];
            else                   c = 1;
          end
          m_prev = cur;
        end
      end
      if (bad) m_err = 1; else if (err_clr) m_err = 0;
      if (pos_clr) begin m_pos = 0; m_evt = 0; end
      else begin
        m_evt = c;
        if (c) begin m_up = u; m_pos = u ? m_pos + 1 : m_pos - 1; end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (cmp_on && rst_n) begin
    chk(position == m_pos, "R3 position vs model", position, m_pos);
    chk(dir_fwd == m_dir, "R6 dir vs model", dir_fwd, m_dir);
    chk(err_flag == m_err, "R7 err vs model", err_flag, m_err);
    chk(evt_valid == m_evt, "R10 evt vs model", evt_valid, m_evt);
    if (m_evt) chk(evt_up == m_up, "R10 evt_up vs model", evt_up, m_up);
  end

  task automatic mvc(input logic [1:0] ba, input logic pc, input logic ec);
    @(negedge clk); {ph_b, ph_a} = ba; st = ba;
    repeat (3) @(negedge clk);
    smp_en = 1; pos_clr = pc; err_clr = ec;
    @(negedge clk); smp_en = 0; pos_clr = 0; err_clr = 0;
  endtask

  task automatic mv(input logic [1:0] ba);
    mvc(ba, 1'b0, 1'b0);
  endtask

  task automatic fwd_cycle();
    mv(2'b01); mv(2'b11); mv(2'b10); mv(2'b00);
  endtask

  task automatic rev_cycle();
    mv(2'b10); mv(2'b11); mv(2'b01); mv(2'b00);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++; done = 1;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] p0;
    repeat (4) @(negedge clk);
    chk(position == 0 && dir_fwd && !err_flag && !evt_valid, "R1 reset state",
        {position, dir_fwd, err_flag, evt_valid}, 32'h0 << 3 | 4);
    rst_n = 1; cmp_on = 1;

    mode = 2'd2;
    mv(2'b11);  // R12 prime with non-zero state
    chk(position == 0 && !err_flag && !evt_valid, "R12 prime", position, 0);
    mv(2'b10); mv(2'b00);
    chk(position == 2, "R3 two forward steps", position, 2);
    fwd_cycle();
    chk(position == 6, "R3 forward cycle 4x", position, 6);
    mode = 2'd3; mv(2'b10);
    chk(position == 5 && evt_valid && !evt_up, "R3 mode 3 reverse", position, 5);
    mv(2'b00);

    mode = 2'd1; p0 = position; fwd_cycle();
    chk(position == p0 + 2, "R4 forward cycle 2x", position, p0 + 2);
    p0 = position; rev_cycle();
    chk(position == p0 - 2, "R4 reverse cycle 2x", position, p0 - 2);

    mode = 2'd0; p0 = position; fwd_cycle();
    chk(position == p0 + 1, "R5 forward cycle 1x", position, p0 + 1);
    p0 = position; rev_cycle();
    chk(position == p0 - 1, "R5 reverse cycle 1x", position, p0 - 1);

    p0 = position; mv(2'b10);
    chk(!dir_fwd && !evt_valid && position == p0, "R6 uncounted reverse", dir_fwd, 0);
    mv(2'b00);
    chk(dir_fwd && !evt_valid, "R6 uncounted forward", dir_fwd, 1);

    mode = 2'd2; p0 = position;
    @(negedge clk) ph_a = 1; @(negedge clk) ph_a = 0;
    repeat (4) @(negedge clk);
    smp_en = 1; @(negedge clk) smp_en = 0;
    chk(position == p0 && !evt_valid, "R2 glitch between strobes", position, p0);

    mv(2'b11);
    chk(err_flag && position == p0 && !evt_valid && dir_fwd, "R7 double change", err_flag, 1);
    @(negedge clk) err_clr = 1; @(negedge clk) err_clr = 0;
    chk(!err_flag, "R8 clear", err_flag, 0);
    mvc(2'b00, 1'b0, 1'b1);
    chk(err_flag, "R8 set wins over clear", err_flag, 1);
    @(negedge clk) err_clr = 1; @(negedge clk) err_clr = 0;

    mvc(2'b01, 1'b1, 1'b0);
    chk(position == 0 && !evt_valid, "R9 clear beats count", position, 0);
    mv(2'b00);
    chk(position == 32'hFFFF_FFFF && evt_valid && !evt_up, "R11 wrap below zero",
        position, 32'hFFFF_FFFF);
    @(negedge clk);
    chk(!evt_valid, "R10 single-cycle event", evt_valid, 0);

    for (int i = 0; i < 3000; i++) begin
      int r;
      if (i % 200 == 0) mode = 2'($urandom_range(0, 3));
      @(negedge clk);
      r = $urandom_range(0, 9);
      if (r < 4)      st = 2'((ord(st) == 3) ? 2'b00 : (st ^ ((ord(st) % 2 == 0) ? 2'b01 : 2'b10)));
      else if (r < 8) st = (ord(st) % 2 == 0) ? st ^ 2'b10 : st ^ 2'b01;
      else if (r < 9) st = ~st;
      {ph_b, ph_a} = st;
      repeat ($urandom_range(0, 4)) @(negedge clk);
      smp_en = 1;
      pos_clr = ($urandom_range(0, 40) == 0);
      err_clr = ($urandom_range(0, 10) == 0);
      @(negedge clk); smp_en = 0; pos_clr = 0; err_clr = 0;
    end

    repeat (5) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule